// File: doc/BRIEF.md
# Fractional Local Time and Cycle Timer

This block keeps a node's view of network time on a time-triggered CAN bus. A phase accumulator divides the system clock by a programmable ratio that has an integer part and a fractional part. The ratio is the number of system clocks per fractional time step. Each accumulator step adds one fractional unit to a local time counter. That counter holds an integer count of network time units in its upper bits and FRAC_W fractional bits below them.

At every start-of-frame strobe the block latches the running local time as a sync mark. The frame's identifier does not matter. When the surrounding controller later confirms that the frame was a valid reference frame, that sync mark is promoted to the ref mark. The cycle time is the local time minus the ref mark, taken modulo the counter width, so it restarts from the instant each basic cycle began.

The basic-cycle counter also updates on each valid reference frame. A time master advances its own counter and wraps it after a programmable maximum. Any other node copies the count carried in the received frame. The ratio is an ordinary input. A new ratio value is picked up at a step boundary, so software may hold it constant or retune it at run time.

Top module: `ntu_cycle_timer`

## Requirements
- R1: While reset is low, and on the first sample after reset is released before any clock edge, local time, sync mark, ref mark, cycle time and cycle count all read zero.
- R2: With a constant ratio of integer part I ≥ 1 and fractional part F (scaled by 2^RFW), the n-th local-time step lands on clock edge 1 + (n-1)·I + floor((n-1)·F / 2^RFW). Edges are counted from reset release. Each step adds exactly one fractional unit to local time.
- R3: Local time wraps to zero after its all-ones value. It is a plain modulo-2^(INT_W+FRAC_W) counter.
- R4: On an edge where the start-of-frame strobe is high, the sync mark takes the local time value present just before that edge.
- R5: On an edge where the reference-valid strobe is high, the ref mark takes the sync mark value present just before that edge.
- R6: Cycle time always equals local time minus ref mark, modulo 2^(INT_W+FRAC_W). It stays correct across a local-time wrap.
- R7: As time master, the cycle count advances by one on each reference-valid strobe. On a strobe where the count already equals or exceeds the programmed maximum, it returns to 0.
- R8: As a non-master, the cycle count loads the received cycle count on each reference-valid strobe.
- R9: A ratio change does not shorten or stretch the step already in progress. The new ratio sets the length of the step that follows the next step boundary.
- R10: A start-of-frame strobe without a reference-valid strobe leaves the ref mark, and hence the cycle time origin, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ratio_int_i | input | RIW | Integer part of system clocks per fractional step |
| ratio_frac_i | input | RFW | Fractional part of system clocks per fractional step |
| sof_i | input | 1 | Start-of-frame strobe, one cycle |
| ref_valid_i | input | 1 | Last frame confirmed as valid reference frame, one cycle |
| rx_cycle_i | input | CCW | Cycle count received in the reference frame |
| master_i | input | 1 | Node is current time master |
| cc_max_i | input | CCW | Highest cycle count before wrap (master) |
| local_time_o | output | INT_W+FRAC_W | Local time, integer and fractional parts |
| sync_mark_o | output | INT_W+FRAC_W | Local time latched at last start of frame |
| ref_mark_o | output | INT_W+FRAC_W | Sync mark of the last valid reference frame |
| cycle_time_o | output | INT_W+FRAC_W | Local time minus ref mark |
| cycle_cnt_o | output | CCW | Current basic-cycle count |

## Verification
The bench builds the block with INT_W=4, FRAC_W=3, RIW=3, RFW=3 and CCW=3. This makes local time 7 bits wide, so it wraps after 128 steps. With these widths the bench can sweep every integer part from 1 to 7 against every fractional part from 0 to 7. For each ratio it compares every cycle of a 150-edge window against the closed-form step schedule. The same sweep drives local time through its wrap at the fastest ratio. A separate run pins cycle time across the wrap. Another run checks that a mid-step ratio change takes effect only after the next boundary. The 3-bit cycle count lets the bench run the master wrap at a small maximum and load every received count value.

// File: rtl/ntu_cycle_timer.sv
module ntu_cycle_timer #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 3,
  parameter int RIW    = 8,
  parameter int RFW    = 8,
  parameter int CCW    = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [RIW-1:0]          ratio_int_i,
  input  logic [RFW-1:0]          ratio_frac_i,
  input  logic                    sof_i,
  input  logic                    ref_valid_i,
  input  logic [CCW-1:0]          rx_cycle_i,
  input  logic                    master_i,
  input  logic [CCW-1:0]          cc_max_i,
  output logic [INT_W+FRAC_W-1:0] local_time_o,
  output logic [INT_W+FRAC_W-1:0] sync_mark_o,
  output logic [INT_W+FRAC_W-1:0] ref_mark_o,
  output logic [INT_W+FRAC_W-1:0] cycle_time_o,
  output logic [CCW-1:0]          cycle_cnt_o
);
  localparam int LTW = INT_W + FRAC_W;

  logic [RIW-1:0] cnt;
  logic [RIW:0]   per;
  logic [RFW-1:0] acc;
  logic [LTW-1:0] lt, sync_q, ref_q;
  logic [CCW-1:0] cc;

  wire [RFW:0] acc_sum = {1'b0, acc} + {1'b0, ratio_frac_i};
  wire [RIW:0] cnt_inc = {1'b0, cnt} + (RIW+1)'(1);
  wire         step    = cnt_inc >= per;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt <= '0;
      acc <= '0;
      per <= (RIW+1)'(1);
      lt  <= '0;
    end else if (step) begin
      cnt <= '0;
      acc <= acc_sum[RFW-1:0];
      per <= {1'b0, ratio_int_i} + (RIW+1)'(acc_sum[RFW]);
      lt  <= lt + LTW'(1);
    end else begin
      cnt <= cnt_inc[RIW-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync_q <= '0;
      ref_q  <= '0;
      cc     <= '0;
    end else begin
      if (sof_i) sync_q <= lt;
      if (ref_valid_i) begin
        ref_q <= sync_q;
        if (!master_i)          cc <= rx_cycle_i;
        else if (cc >= cc_max_i) cc <= '0;
        else                    cc <= cc + CCW'(1);
      end
    end
  end

  assign local_time_o = lt;
  assign sync_mark_o  = sync_q;
  assign ref_mark_o   = ref_q;
  assign cycle_time_o = lt - ref_q;
  assign cycle_cnt_o  = cc;
endmodule

module ntu_cycle_timer_chk #(
  parameter int LTW = 19,
  parameter int CCW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sof_i,
  input logic           ref_valid_i,
  input logic           master_i,
  input logic [CCW-1:0] rx_cycle_i,
  input logic [CCW-1:0] cc_max_i,
  input logic [LTW-1:0] local_time_o,
  input logic [LTW-1:0] sync_mark_o,
  input logic [LTW-1:0] ref_mark_o,
  input logic [LTW-1:0] cycle_time_o,
  input logic [CCW-1:0] cycle_cnt_o
);
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (local_time_o == $past(local_time_o)) ||
             (local_time_o == $past(local_time_o) + LTW'(1)));

  a_r4_sync_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> sync_mark_o == $past(local_time_o));

  a_r5_ref_promote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i |=> ref_mark_o == $past(sync_mark_o));

  a_r10_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> $stable(ref_mark_o));

  a_r7_master_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && master_i && cycle_cnt_o >= cc_max_i) |=> cycle_cnt_o == '0);

  a_r8_slave_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && !master_i) |=> cycle_cnt_o == $past(rx_cycle_i));

  a_r7_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> $stable(cycle_cnt_o));
endmodule

bind ntu_cycle_timer ntu_cycle_timer_chk #(.LTW(INT_W+FRAC_W), .CCW(CCW)) u_chk (
  .clk_i, .rst_ni, .sof_i, .ref_valid_i, .master_i, .rx_cycle_i, .cc_max_i,
  .local_time_o, .sync_mark_o, .ref_mark_o, .cycle_time_o, .cycle_cnt_o
);

// File: tb/ntu_cycle_timer_tb.sv
module ntu_cycle_timer_tb;
  localparam int INT_W = 4, FRAC_W = 3, RIW = 3, RFW = 3, CCW = 3;
  localparam int LTW = INT_W + FRAC_W;
  localparam int MOD = 1 << LTW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [RIW-1:0] ratio_int = 3'd1;
  logic [RFW-1:0] ratio_frac = '0;
  logic sof = 1'b0, ref_valid = 1'b0, master = 1'b0;
  logic [CCW-1:0] rx_cycle = '0, cc_max = '0;
  logic [LTW-1:0] lt, syncm, refm, ct;
  logic [CCW-1:0] ccnt;

  int checks = 0, fails = 0, k = 0;

  always #2 clk = ~clk;

  ntu_cycle_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RIW(RIW), .RFW(RFW), .CCW(CCW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ratio_int_i(ratio_int), .ratio_frac_i(ratio_frac),
    .sof_i(sof), .ref_valid_i(ref_valid), .rx_cycle_i(rx_cycle), .master_i(master),
    .cc_max_i(cc_max), .local_time_o(lt), .sync_mark_o(syncm), .ref_mark_o(refm),
    .cycle_time_o(ct), .cycle_cnt_o(ccnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1; k++;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sof = 0; ref_valid = 0;
    step(); step();
    chk("R1 lt", lt, 0); chk("R1 sync", syncm, 0); chk("R1 ref", refm, 0);
    chk("R1 ct", ct, 0); chk("R1 cc", ccnt, 0);
    rst_ni = 1'b1; k = 0;
    chk("R1 lt after release", lt, 0);
  endtask

  function automatic int exp_steps(input int edges, input int ii, input int ff);
    int n = 0;
    for (int m = 0; m * ii + (m * ff) / (1 << RFW) <= edges - 1; m++) n++;
    return n;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    // R2 and R3: every ratio of the small configuration, wraps at the fast end
    for (int ii = 1; ii < (1 << RIW); ii++) begin
      for (int ff = 0; ff < (1 << RFW); ff++) begin
        ratio_int = RIW'(ii); ratio_frac = RFW'(ff);
        do_reset();
        for (int e = 1; e <= 150; e++) begin
          step();
          chk((ii == 1) ? "R2/R3 step schedule" : "R2 step schedule",
              lt, exp_steps(k, ii, ff) % MOD);
        end
      end
    end

    // R9: ratio change mid-step takes effect after the next boundary
    ratio_int = 3'd4; ratio_frac = '0;
    do_reset();
    step(); step();
    ratio_int = 3'd2;
    step(); chk("R9 k3", lt, 1);
    step(); chk("R9 k4", lt, 1);
    step(); chk("R9 k5 old period kept", lt, 2);
    step(); chk("R9 k6", lt, 2);
    step(); chk("R9 k7 new period", lt, 3);
    step(); step(); chk("R9 k9", lt, 4);

    // R4, R5, R6, R10 with one step per edge: lt == k mod 128
    ratio_int = 3'd1; ratio_frac = '0;
    do_reset();
    repeat (10) step();
    sof = 1; step(); sof = 0;
    chk("R4 sync mark", syncm, 10);
    chk("R10 ref unchanged by sof", refm, 0);
    chk("R6 ct before ref", ct, 11);
    repeat (5) step();
    ref_valid = 1; step(); ref_valid = 0;
    chk("R5 ref mark", refm, 10);
    chk("R6 ct after ref", ct, (k - 10) % MOD);
    repeat (20) step();
    sof = 1; step(); sof = 0;
    chk("R4 second sync", syncm, (k - 1) % MOD);
    chk("R10 ref held", refm, 10);
    repeat (130) step();
    chk("R3 lt wrapped", lt, k % MOD);
    chk("R6 ct across wrap", ct, (k - 10) % MOD);
    chk("R10 ref still held", refm, 10);

    // R7: master counting with wrap at 5
    do_reset();
    master = 1; cc_max = 3'd5;
    for (int i = 1; i <= 9; i++) begin
      ref_valid = 1; step(); ref_valid = 0; step();
      chk("R7 master count", ccnt, i % 6);
    end
    cc_max = 3'd0;
    ref_valid = 1; step(); ref_valid = 0;
    chk("R7 wrap when count above max", ccnt, 0);

    // R8: non-master loads every received count
    master = 0;
    for (int v = (1 << CCW) - 1; v >= 0; v--) begin
      rx_cycle = CCW'(v);
      ref_valid = 1; step(); ref_valid = 0;
      chk("R8 received count", ccnt, v);
      rx_cycle = CCW'(v + 3); step();
      chk("R8 held between frames", ccnt, v);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule